// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block sits beside a serial port's transmit and receive engines and merges their interrupt conditions into a single identification byte and one active-high interrupt request. Five sources feed it. Two are levels that the block follows directly: receive data at or above the trigger level, and receive timeout. Three are events that it remembers until software acknowledges them: transmit holding register became empty, a receive line error or break, and a modem status change. Each source has its own enable bit.

Software reads the identification byte to learn which source to service. Bit 0 is low while something is pending. Bits 3:1 give the cause of the highest-priority active source. Bits 7:6 show whether FIFO mode is on. The register-access strobes arrive from the bus decoder: reading the byte, writing transmit data, reading line status and reading modem status. They acknowledge the remembered events according to fixed clearing rules.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source active and `fifo_mode` low, `id_byte` reads 0x01 and `irq` is low.
- R2: `irq` is high exactly when at least one enabled source is active. `id_byte[0]` is its inverse: 0 means pending and 1 means none pending.
- R3: `id_byte[3:1]` carries the cause code: 3 for line status, 2 for receive data, 6 for receive timeout, 1 for transmit holding empty and 0 for modem status. When nothing is pending it is 0. Bits 5:4 always read 0.
- R4: `id_byte[7:6]` reads 11 when `fifo_mode` is high and 00 when it is low, whatever the pending state.
- R5: `src_en` maps bit 0 to receive data, bit 1 to transmit empty, bit 2 to line status, bit 3 to modem status and bit 4 to receive timeout. A 0 bit keeps that source out of `irq` and `id_byte`. A line or modem event that arrives while masked is still remembered, and it is reported once its enable bit is set.
- R6: Priority, highest first, is line status, then receive data, then receive timeout, then transmit empty, then modem status.
- R7: A transmit-empty event is recorded on the cycle after `tx_hold_empty` and `src_en[1]` first become high together. It is cleared by a `tx_wr` strobe. It is also cleared by an `id_rd` strobe, but only while `id_byte` reports cause 1.
- R8: An `id_rd` strobe while some other cause is reported leaves a pending transmit-empty event in place.
- R9: A `line_rd` strobe clears a remembered line event and a `modem_rd` strobe clears a remembered modem event. If a new event arrives in the same cycle as the clear, the event stays pending.
- R10: Receive data and receive timeout are levels. They affect `id_byte` and `irq` in the same cycle as the input, with no latching. They clear when their input falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 5 | Per-source enable bits (mapping in R5) |
| rx_lvl_hit | input | 1 | Receive data at or above trigger level (level) |
| rx_timeout | input | 1 | Receive timeout condition (level) |
| tx_hold_empty | input | 1 | Transmit holding register empty (level; rising edge records event) |
| line_evt | input | 1 | One-cycle receive line error or break event |
| modem_evt | input | 1 | One-cycle modem status change event |
| fifo_mode | input | 1 | FIFO mode is enabled |
| id_rd | input | 1 | Identification byte read strobe |
| tx_wr | input | 1 | Transmit data write strobe |
| line_rd | input | 1 | Line status read strobe |
| modem_rd | input | 1 | Modem status read strobe |
| id_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is an identification read that arrives while a transmit-empty event is pending but hidden behind a higher-priority line event. The read must not consume the hidden event. The bench first builds that state with an aligned rising edge on `tx_hold_empty` and a line event, then reads the identification byte. It then acknowledges the line event and expects cause 1 to surface. The bench also sweeps every combination of the five enables against every combination of the five source states, with the FIFO mode toggled along the way. This covers each masked-but-remembered event and each pairing in the priority order, and every result is compared against an arithmetic model.

// File: rtl/uart_irq_ident_pkg.sv
package uart_irq_ident_pkg;
   localparam int SRC_N   = 5;
   localparam int SRC_RXD = 0;
   localparam int SRC_THR = 1;
   localparam int SRC_LSR = 2;
   localparam int SRC_MSR = 3;
   localparam int SRC_TMO = 4;

   localparam int EVT_N   = 3;
   localparam int EVT_THR = 0;
   localparam int EVT_LSR = 1;
   localparam int EVT_MSR = 2;

   typedef enum logic [2:0] {
      CAUSE_MSR = 3'd0,
      CAUSE_THR = 3'd1,
      CAUSE_RXD = 3'd2,
      CAUSE_LSR = 3'd3,
      CAUSE_TMO = 3'd6
   } cause_e;
endpackage

// File: rtl/uart_irq_evt_latch.sv
module uart_irq_evt_latch #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= 1'b0;
      end else begin
         if (SET_WINS) begin
            if (set_i)      q_o <= 1'b1;
            else if (clr_i) q_o <= 1'b0;
         end else begin
            if (clr_i)      q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_ident_pkg::*;
#(
   parameter int ID_W      = 8,
   parameter int CAUSE_W   = 3,
   parameter int FIFO_BITS = 2
) (
   input  logic [SRC_N-1:0] active_i,
   input  logic             fifo_mode_i,
   output logic [ID_W-1:0]  id_o,
   output logic             irq_o
);
   localparam int GAP_W = ID_W - 1 - CAUSE_W - FIFO_BITS;

   logic [CAUSE_W-1:0] cause;
   logic               pending;

   always_comb begin
      pending = |active_i;
      if (active_i[SRC_LSR])      cause = CAUSE_W'(CAUSE_LSR);
      else if (active_i[SRC_RXD]) cause = CAUSE_W'(CAUSE_RXD);
      else if (active_i[SRC_TMO]) cause = CAUSE_W'(CAUSE_TMO);
      else if (active_i[SRC_THR]) cause = CAUSE_W'(CAUSE_THR);
      else                        cause = CAUSE_W'(CAUSE_MSR);
   end

   assign irq_o = pending;

   generate
      if (GAP_W > 0) begin : g_gap
         assign id_o = {{FIFO_BITS{fifo_mode_i}}, {GAP_W{1'b0}}, cause, ~pending};
      end else begin : g_nogap
         assign id_o = {{FIFO_BITS{fifo_mode_i}}, cause, ~pending};
      end
   endgenerate
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_ident_pkg::*;
#(
   parameter int ID_W      = 8,
   parameter int CAUSE_W   = 3,
   parameter int FIFO_BITS = 2,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] src_en,
   input  logic             rx_lvl_hit,
   input  logic             rx_timeout,
   input  logic             tx_hold_empty,
   input  logic             line_evt,
   input  logic             modem_evt,
   input  logic             fifo_mode,
   input  logic             id_rd,
   input  logic             tx_wr,
   input  logic             line_rd,
   input  logic             modem_rd,
   output logic [ID_W-1:0]  id_byte,
   output logic             irq
);
   generate
      if (ID_W < 1 + CAUSE_W + FIFO_BITS) begin : g_bad_width
         $error("identification byte too narrow for its fields");
      end
      if (CAUSE_W < 3) begin : g_bad_cause
         $error("cause field cannot hold all codes");
      end
   endgenerate

   logic             thr_cond, thr_cond_q;
   logic [EVT_N-1:0] evt_set, evt_clr, evt_q;
   logic [SRC_N-1:0] active;
   logic             thr_reported;

   assign thr_cond = tx_hold_empty & src_en[SRC_THR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_cond_q <= 1'b0;
      else        thr_cond_q <= thr_cond;
   end

   assign thr_reported = ~id_byte[0] && (id_byte[CAUSE_W:1] == CAUSE_W'(CAUSE_THR));

   assign evt_set[EVT_THR] = thr_cond & ~thr_cond_q;
   assign evt_clr[EVT_THR] = tx_wr | (id_rd & thr_reported);
   assign evt_set[EVT_LSR] = line_evt;
   assign evt_clr[EVT_LSR] = line_rd;
   assign evt_set[EVT_MSR] = modem_evt;
   assign evt_clr[EVT_MSR] = modem_rd;

   genvar gi;
   generate
      for (gi = 0; gi < EVT_N; gi++) begin : g_evt
         uart_irq_evt_latch #(.SET_WINS(SET_WINS)) latch_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_set[gi]),
            .clr_i (evt_clr[gi]),
            .q_o   (evt_q[gi])
         );
      end
   endgenerate

   assign active[SRC_RXD] = rx_lvl_hit      & src_en[SRC_RXD];
   assign active[SRC_TMO] = rx_timeout      & src_en[SRC_TMO];
   assign active[SRC_THR] = evt_q[EVT_THR]  & src_en[SRC_THR];
   assign active[SRC_LSR] = evt_q[EVT_LSR]  & src_en[SRC_LSR];
   assign active[SRC_MSR] = evt_q[EVT_MSR]  & src_en[SRC_MSR];

   uart_irq_prio #(
      .ID_W      (ID_W),
      .CAUSE_W   (CAUSE_W),
      .FIFO_BITS (FIFO_BITS)
   ) prio_i (
      .active_i    (active),
      .fifo_mode_i (fifo_mode),
      .id_o        (id_byte),
      .irq_o       (irq)
   );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
   import uart_irq_ident_pkg::*;
#(
   parameter int ID_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SRC_N-1:0] src_en,
   input logic             tx_hold_empty,
   input logic             line_evt,
   input logic             modem_evt,
   input logic             fifo_mode,
   input logic             tx_wr,
   input logic             modem_rd,
   input logic [ID_W-1:0]  id_byte,
   input logic             irq
);
   p_irq_vs_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq != id_byte[0]);

   p_fifo_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      id_byte[7:6] == {2{fifo_mode}});

   p_all_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_en == '0) |-> (id_byte[0] && !irq));

   p_line_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_evt && src_en[SRC_LSR]) |=> (id_byte[3:0] == 4'h6 || !src_en[SRC_LSR]));

   p_thr_wr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && !(tx_hold_empty && src_en[SRC_THR])) |=> (id_byte[3:1] != 3'd1));

   p_modem_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (modem_rd && !modem_evt) |=> (id_byte[3:0] != 4'h0));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ID_W(ID_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .src_en        (src_en),
   .tx_hold_empty (tx_hold_empty),
   .line_evt      (line_evt),
   .modem_evt     (modem_evt),
   .fifo_mode     (fifo_mode),
   .tx_wr         (tx_wr),
   .modem_rd      (modem_rd),
   .id_byte       (id_byte),
   .irq           (irq)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] src_en = '0;
   logic       rx_lvl_hit = 0, rx_timeout = 0, tx_hold_empty = 0;
   logic       line_evt = 0, modem_evt = 0, fifo_mode = 0;
   logic       id_rd = 0, tx_wr = 0, line_rd = 0, modem_rd = 0;
   logic [7:0] id_byte;
   logic       irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   uart_irq_ident dut_i (
      .clk(clk), .rst_n(rst_n), .src_en(src_en),
      .rx_lvl_hit(rx_lvl_hit), .rx_timeout(rx_timeout),
      .tx_hold_empty(tx_hold_empty), .line_evt(line_evt),
      .modem_evt(modem_evt), .fifo_mode(fifo_mode), .id_rd(id_rd),
      .tx_wr(tx_wr), .line_rd(line_rd), .modem_rd(modem_rd),
      .id_byte(id_byte), .irq(irq)
   );

   // expected byte from R2..R6: s bits 0 rx, 1 thr, 2 line, 3 modem, 4 timeout
   function automatic logic [7:0] model(input logic [4:0] en, input logic [4:0] s,
                                        input logic fm);
      logic [4:0] a;
      int code;
      a = en & s;
      if (a[2])      code = 3;
      else if (a[0]) code = 2;
      else if (a[4]) code = 6;
      else if (a[1]) code = 1;
      else           code = 0;
      return 8'((fm ? 192 : 0) + (a != 0 ? code * 2 : 1));
   endfunction

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: id_byte=%02h expected %02h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq=%0b expected %0b", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk);
      line_rd = 1; modem_rd = 1; tx_wr = 1; tx_hold_empty = 0;
      rx_lvl_hit = 0; rx_timeout = 0; line_evt = 0; modem_evt = 0; id_rd = 0;
      @(negedge clk);
      line_rd = 0; modem_rd = 0; tx_wr = 0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check8("R1 reset", id_byte, 8'h01);
      check1("R1 reset", irq, 1'b0);
      rst_n = 1;

      // R2 R3 R4 R5 R6 R10 exhaustive sweep
      for (int e = 0; e < 32; e++) begin
         for (int s = 0; s < 32; s++) begin
            logic [4:0] ev, sv;
            ev = 5'(e); sv = 5'(s);
            clear_all();
            src_en = ev; fifo_mode = ev[0] ^ sv[0] ^ sv[3];
            tx_hold_empty = sv[1]; rx_lvl_hit = sv[0]; rx_timeout = sv[4];
            line_evt = sv[2]; modem_evt = sv[3];
            @(negedge clk);
            line_evt = 0; modem_evt = 0;
            #1;
            check8("R3 R5 R6 sweep", id_byte, model(ev, sv, fifo_mode));
            check1("R2 sweep", irq, (ev & sv) != 0);
         end
      end
      fifo_mode = 0;

      // R10 level follows input same cycle
      clear_all();
      src_en = 5'h1F; rx_timeout = 1; #1;
      check8("R10 timeout level", id_byte, 8'h0C);
      rx_lvl_hit = 1; #1;
      check8("R10 data over timeout", id_byte, 8'h04);
      rx_lvl_hit = 0; rx_timeout = 0; #1;
      check8("R10 level release", id_byte, 8'h01);

      // R7 clear by identification read while reported
      clear_all();
      src_en = 5'h02; tx_hold_empty = 1;
      @(negedge clk); #1;
      check8("R7 thr set", id_byte, 8'h02);
      id_rd = 1;
      @(negedge clk); id_rd = 0; #1;
      check8("R7 thr cleared by id read", id_byte, 8'h01);
      @(negedge clk); #1;
      check8("R7 no re-arm while level held", id_byte, 8'h01);

      // R8 hidden thr survives id read
      clear_all();
      src_en = 5'h06; tx_hold_empty = 1; line_evt = 1;
      @(negedge clk); line_evt = 0; #1;
      check8("R8 line shown", id_byte, 8'h06);
      id_rd = 1;
      @(negedge clk); id_rd = 0; line_rd = 1;
      @(negedge clk); line_rd = 0; #1;
      check8("R8 thr survives read", id_byte, 8'h02);
      tx_wr = 1;
      @(negedge clk); tx_wr = 0; #1;
      check8("R7 thr cleared by write", id_byte, 8'h01);

      // R5 masked modem event remembered
      clear_all();
      src_en = 5'h00; modem_evt = 1;
      @(negedge clk); modem_evt = 0; #1;
      check8("R5 masked hidden", id_byte, 8'h01);
      src_en = 5'h08; #1;
      check8("R5 reported on enable", id_byte, 8'h00);
      check1("R5 irq on enable", irq, 1'b1);

      // R9 set wins over same-cycle clear, then clear
      clear_all();
      src_en = 5'h04; line_evt = 1; line_rd = 1;
      @(negedge clk); line_evt = 0; line_rd = 0; #1;
      check8("R9 set wins", id_byte, 8'h06);
      line_rd = 1;
      @(negedge clk); line_rd = 0; #1;
      check8("R9 line cleared", id_byte, 8'h01);
      src_en = 5'h08; modem_evt = 1;
      @(negedge clk); modem_evt = 0; modem_rd = 1;
      @(negedge clk); modem_rd = 0; #1;
      check8("R9 modem cleared", id_byte, 8'h01);

      // R4 fifo bits with nothing pending
      fifo_mode = 1; #1;
      check8("R4 fifo idle", id_byte, 8'hC1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule